// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, and keeps one capture register per direction. The A-to-B register samples bus A on every rising edge of its own clock. The B-to-A register samples bus B on every rising edge of a second, independent clock. Register capture never depends on the output controls.

An active-low enable and a direction input choose which bus, if either, the block drives. For each direction, a select input chooses what the driven bus shows: live data from the opposite bus, or the contents of the register for that direction.

Each bidirectional bus appears as three signals: an input vector, an output vector and one output-enable bit. This keeps tri-state logic out of the design. A parameter chooses between a straight data path and an inverting one.

Top module: `bus_xcvr_reg`

## Requirements
- R1: An active-low asynchronous reset (`rstN`) clears both registers to zero. While reset is held, a bus that is driven in stored mode shows all zeros (all ones in the inverting variant).
- R2: The A-to-B register loads `aIn` on every rising edge of `clkAb`, whatever the values of `enN`, `dirAtoB` and the selects.
- R3: The B-to-A register loads `bIn` on every rising edge of `clkBa`, whatever the values of the output controls. A value loaded in the current cycle is visible at once on a bus that is driven in stored mode.
- R4: When `enN` is 1, both `aOe` and `bOe` are 0 (isolation).
- R5: When `enN` is 0 and `dirAtoB` is 1, `bOe` is 1 and `aOe` is 0. When `enN` is 0 and `dirAtoB` is 0, `aOe` is 1 and `bOe` is 0.
- R6: While `bOe` is 1, `bOut` equals the live `aIn` when `selAb` is 0, and equals the A-to-B register when `selAb` is 1.
- R7: While `aOe` is 1, `aOut` equals the live `bIn` when `selBa` is 0, and equals the B-to-A register when `selBa` is 1.
- R8: A change on a select input switches the driven output between the live source and the stored source with no clock edge.
- R9: With `INVERT`=1, every value that R6 and R7 place on `aOut` or `bOut` appears bitwise complemented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous reset, active low |
| clkAb | input | 1 | Capture clock of the A-to-B register |
| clkBa | input | 1 | Capture clock of the B-to-A register |
| enN | input | 1 | Output enable, active low |
| dirAtoB | input | 1 | 1: drive bus B; 0: drive bus A |
| selAb | input | 1 | Source for bus B: 0 live A, 1 stored |
| selBa | input | 1 | Source for bus A: 0 live B, 1 stored |
| aIn | input | WIDTH | Value present on bus A |
| aOut | output | WIDTH | Value driven onto bus A |
| aOe | output | 1 | Bus A output enable |
| bIn | input | WIDTH | Value present on bus B |
| bOut | output | WIDTH | Value driven onto bus B |
| bOe | output | 1 | Bus B output enable |

## Verification
The bench first holds reset with stored mode selected, which exposes the cleared registers. It then loads the registers in isolation and reads them back later with different live values on the buses, so a stored-path fault cannot pass as a transparent one. Each direction is tried with live data and with stored data using complementary bit patterns, which separates a swapped select from a swapped bus. A capture that arrives in the same cycle as a read, and a select that flips between clock edges, show whether the output mux is combinational. A second instance with inversion enabled receives the same stimulus and is compared against complemented values.

// File: rtl/bus_xcvr_pkg.sv
`timescale 1ns/1ps
package bus_xcvr_pkg;
  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic driveA;      // bus A output enable
    logic driveB;      // bus B output enable
    logic aFromStore;  // bus A shows the B-to-A register
    logic bFromStore;  // bus B shows the A-to-B register
  } xcvrCtrl_t;
endpackage

// File: rtl/bus_xcvr_ctrl.sv
`timescale 1ns/1ps
module bus_xcvr_ctrl
  import bus_xcvr_pkg::*;
(
  input  logic      enN,
  input  logic      dirAtoB,
  input  logic      selAb,
  input  logic      selBa,
  output xcvrCtrl_t ctrl
);
  always_comb begin
    ctrl.driveB     = !enN && dirAtoB;
    ctrl.driveA     = !enN && !dirAtoB;
    ctrl.bFromStore = selAb;
    ctrl.aFromStore = selBa;
  end
endmodule

// File: rtl/bus_xcvr_datapath.sv
`timescale 1ns/1ps
module bus_xcvr_datapath
  import bus_xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             rstN,
  input  logic             clkAb,
  input  logic             clkBa,
  input  xcvrCtrl_t        ctrl,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);
  logic [WIDTH-1:0] regAb;
  logic [WIDTH-1:0] regBa;
  logic [WIDTH-1:0] srcB;
  logic [WIDTH-1:0] srcA;

  // capture registers; they ignore the output controls
  always_ff @(posedge clkAb or negedge rstN) begin
    if (!rstN) regAb <= '0;
    else       regAb <= aIn;
  end

  always_ff @(posedge clkBa or negedge rstN) begin
    if (!rstN) regBa <= '0;
    else       regBa <= bIn;
  end

  // live or stored source for each direction
  always_comb begin
    srcB = ctrl.bFromStore ? regAb : aIn;
    srcA = ctrl.aFromStore ? regBa : bIn;
  end

  generate
    if (INVERT) begin : g_inv
      assign bOut = ~srcB;
      assign aOut = ~srcA;
    end else begin : g_pass
      assign bOut = srcB;
      assign aOut = srcA;
    end
  endgenerate

  assign aOe = ctrl.driveA;
  assign bOe = ctrl.driveB;

  // R2: the register holds the value of aIn from the previous clkAb edge
  p_capture_r2: assert property (@(posedge clkAb) disable iff (!rstN)
    $past(rstN) |-> regAb == $past(aIn));

  // R3: the register holds the value of bIn from the previous clkBa edge
  p_capture_r3: assert property (@(posedge clkBa) disable iff (!rstN)
    $past(rstN) |-> regBa == $past(bIn));
endmodule

// File: rtl/bus_xcvr_reg.sv
`timescale 1ns/1ps
module bus_xcvr_reg #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             rstN,
  input  logic             clkAb,
  input  logic             clkBa,
  input  logic             enN,
  input  logic             dirAtoB,
  input  logic             selAb,
  input  logic             selBa,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);
  import bus_xcvr_pkg::*;
  localparam logic [WIDTH-1:0] INV_MASK = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  xcvrCtrl_t ctrl;

  bus_xcvr_ctrl u_ctrl (
    .enN(enN), .dirAtoB(dirAtoB), .selAb(selAb), .selBa(selBa), .ctrl(ctrl)
  );

  bus_xcvr_datapath #(.WIDTH(WIDTH), .INVERT(INVERT)) u_dp (
    .rstN(rstN), .clkAb(clkAb), .clkBa(clkBa), .ctrl(ctrl),
    .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

  // R4: isolation drives neither bus
  p_isolate_r4: assert property (@(posedge clkAb) disable iff (!rstN)
    enN |-> (!aOe && !bOe));

  // R5: never both buses at once, and exactly one while enabled
  p_one_side_r5: assert property (@(posedge clkAb) disable iff (!rstN)
    !enN |-> $countones({aOe, bOe}) == 1);

  p_dir_r5: assert property (@(posedge clkAb) disable iff (!rstN)
    (!enN && dirAtoB) |-> bOe);

  // R6/R9: transparent A-to-B path follows the live A bus
  p_live_b_r6: assert property (@(posedge clkAb) disable iff (!rstN)
    (bOe && !selAb) |-> bOut == (aIn ^ INV_MASK));

  // R7/R9: transparent B-to-A path follows the live B bus
  p_live_a_r7: assert property (@(posedge clkAb) disable iff (!rstN)
    (aOe && !selBa) |-> aOut == (bIn ^ INV_MASK));
endmodule

// File: tb/bus_xcvr_reg_tb.sv
`timescale 1ns/1ps
module bus_xcvr_reg_tb;
  localparam int W = 8;

  logic clkAb = 1'b0;
  logic clkBa = 1'b0;
  logic rstN = 1'b0;
  logic enN = 1'b1;
  logic dirAtoB = 1'b0;
  logic selAb = 1'b0;
  logic selBa = 1'b0;
  logic [W-1:0] aIn = '0;
  logic [W-1:0] bIn = '0;

  logic [W-1:0] aOut, bOut, aOutI, bOutI;
  logic aOe, bOe, aOeI, bOeI;

  int checks = 0;
  int errors = 0;

  always #2.5 clkAb = ~clkAb;  // 200 MHz

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) u_dut (
    .rstN(rstN), .clkAb(clkAb), .clkBa(clkBa), .enN(enN), .dirAtoB(dirAtoB),
    .selAb(selAb), .selBa(selBa), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) u_dutInv (
    .rstN(rstN), .clkAb(clkAb), .clkBa(clkBa), .enN(enN), .dirAtoB(dirAtoB),
    .selAb(selAb), .selBa(selBa), .aIn(aIn), .aOut(aOutI), .aOe(aOeI),
    .bIn(bIn), .bOut(bOutI), .bOe(bOeI)
  );

  // bench model of the two registers, built from R1-style reset and R2/R3 capture
  logic [W-1:0] mAb, mBa;
  always @(posedge clkAb or negedge rstN)
    if (!rstN) mAb <= '0; else mAb <= aIn;
  always @(posedge clkBa or negedge rstN)
    if (!rstN) mBa <= '0; else mBa <= bIn;

  typedef struct {
    string        req;
    logic         expAOe;
    logic         expBOe;
    logic [W-1:0] expA;
    logic [W-1:0] expB;
  } item_t;

  item_t sbq[$];
  item_t cur;

  task automatic checkVal(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: apply one input pattern and push the expected outputs
  task automatic step(string req, logic en, logic dir, logic sa, logic sb,
                      logic [W-1:0] a, logic [W-1:0] b, bit pulseBa);
    item_t it;
    @(posedge clkAb);
    #0.5;
    enN = en; dirAtoB = dir; selAb = sa; selBa = sb; aIn = a; bIn = b;
    if (pulseBa) begin
      #0.5 clkBa = 1'b1;
      #0.5 clkBa = 1'b0;
    end
    #0.1;
    it.req    = req;
    it.expAOe = !enN && !dirAtoB;
    it.expBOe = !enN && dirAtoB;
    it.expB   = selAb ? mAb : aIn;
    it.expA   = selBa ? mBa : bIn;
    sbq.push_back(it);
  endtask

  // monitor: compare both instances away from the clock edge
  always @(negedge clkAb) begin
    while (sbq.size() > 0) begin
      cur = sbq.pop_front();
      checkVal(cur.req, "aOe", {7'd0, aOe}, {7'd0, cur.expAOe});
      checkVal(cur.req, "bOe", {7'd0, bOe}, {7'd0, cur.expBOe});
      checkVal({cur.req, "/R9"}, "aOeInv", {7'd0, aOeI}, {7'd0, cur.expAOe});
      checkVal({cur.req, "/R9"}, "bOeInv", {7'd0, bOeI}, {7'd0, cur.expBOe});
      if (cur.expAOe) begin
        checkVal(cur.req, "aOut", aOut, cur.expA);
        checkVal({cur.req, "/R9"}, "aOutInv", aOutI, ~cur.expA);
      end
      if (cur.expBOe) begin
        checkVal(cur.req, "bOut", bOut, cur.expB);
        checkVal({cur.req, "/R9"}, "bOutInv", bOutI, ~cur.expB);
      end
    end
  end

  // R8: flip a select between edges and look at once
  task automatic flipSelCheck();
    @(negedge clkAb);
    #0.5 selAb = ~selAb;
    #0.5;
    checkVal("R8", "bOut", bOut, selAb ? mAb : aIn);
    checkVal("R8/R9", "bOutInv", bOutI, ~(selAb ? mAb : aIn));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: registers read as zero while reset is held
    step("R1", 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, 8'h5A, 1'b1);
    step("R1", 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h5A, 1'b1);
    @(negedge clkAb);
    rstN = 1'b1;
    // R4: isolation, capture still happens (R2, R3)
    step("R4", 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 8'hC3, 1'b1);
    step("R2", 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
    step("R3", 1'b0, 1'b0, 1'b0, 1'b1, 8'h0F, 8'h00, 1'b0);
    // R5/R6/R7: direction and live paths
    step("R6", 1'b0, 1'b1, 1'b0, 1'b1, 8'h5A, 8'h11, 1'b0);
    step("R7", 1'b0, 1'b0, 1'b1, 1'b0, 8'h22, 8'h96, 1'b0);
    step("R5", 1'b0, 1'b1, 1'b0, 1'b0, 8'h81, 8'h18, 1'b0);
    step("R5", 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h18, 1'b0);
    // R3: capture in the same cycle as a stored read
    step("R3", 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h7E, 1'b1);
    // R6: stored read of A register after live change
    step("R6", 1'b0, 1'b1, 1'b0, 1'b0, 8'hC6, 8'h00, 1'b0);
    step("R6", 1'b0, 1'b1, 1'b1, 1'b0, 8'h39, 8'h00, 1'b0);
    // R2: capture while driving the other bus
    step("R2", 1'b0, 1'b0, 1'b0, 1'b0, 8'h99, 8'h44, 1'b0);
    step("R2", 1'b0, 1'b1, 1'b1, 1'b0, 8'h66, 8'h44, 1'b0);
    // R8
    flipSelCheck();
    flipSelCheck();
    @(negedge clkAb);
    @(negedge clkAb);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule